// File: doc/BRIEF.md
# Turbo Subblock Interleaver Writer

This block reorders one coded stream of a turbo encoder output: the systematic stream, the first parity stream or the second parity stream. A block of D bits (information bits plus four trellis tail bits) is loaded eight bits per clock into a matrix of 32 columns. The matrix is split into eight banks of four columns each. Padding positions take the start of the matrix, so the first data bit lands just after them and the last four bits fill columns 28 to 31 of the last row.

Once the final beat has been taken, the block drains the matrix one bit per clock. It walks the columns in bit-reversed order and reads every row of a column before it moves to the next column. Each output bit carries a padding flag, so a later stage can drop it. For the second parity stream every read position is moved on by one, wrapping at the matrix size. One instance serves each of the three streams.

Top module: `sbi_writer`

## Requirements
- R1: After reset, and after a reset applied in the middle of a block, `in_ready`, `out_valid`, `out_last` and `bank_we` are all 0.
- R2: A `start` pulse while idle latches `blk_len` (D, from 1 to 32*MAX_ROWS) and `stream_sel`, and `in_ready` is 1 in the following cycle. `stream_sel` codes: 0 systematic, 1 first parity, 2 second parity, 3 treated as 1.
- R3: A load takes exactly ceil(D/8) accepted beats (`in_valid` high while `in_ready` is high). Lane j of beat b carries input bit 8b+j, and lanes at or past D are ignored. A cycle with `in_valid` low consumes no beat and raises no write enable. `in_ready` falls in the cycle after the last beat.
- R4: With R = ceil(D/32) rows, the first ND = 32R-D matrix positions are padding, and exactly ND output bits carry `out_null`=1.
- R5: The last four input bits occupy columns 28 to 31 of row R-1.
- R6: For stream codes 0 and 1, output k (k = 0 .. 32R-1) reads matrix position 32*(k mod R) + rev5(k div R), where rev5 reverses the five bits of a column number. Position p holds input bit p-ND, or padding when p < ND.
- R7: For stream code 2, output k reads position (P+1) mod 32R, where P is the position given in R6.
- R8: The first output bit is valid two cycles after the cycle that delivers the last beat. Exactly 32R bits follow on consecutive cycles, and `out_last` marks the final one. Then `out_valid` falls and the block is idle.
- R9: `bank_we` bit n is 1 during an accepted beat exactly when a used lane writes a column in 4n..4n+3. Each accepted beat enables between one and three banks.
- R10: A `start` pulse while a block is loading or draining is ignored, and the block in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new block (honoured only when idle) |
| blk_len | input | LEN_W | Block length D in bits |
| stream_sel | input | 2 | Stream type code |
| in_valid | input | 1 | Input beat valid |
| in_data | input | 8 | Eight input bits, lane 0 is the earliest |
| in_ready | output | 1 | Block is loading and accepts beats |
| bank_we | output | 8 | Per-bank write enables of the current beat |
| out_valid | output | 1 | Output bit valid |
| out_bit | output | 1 | Interleaved bit |
| out_null | output | 1 | Output position is padding |
| out_last | output | 1 | Final output bit of the block |

## Verification
`in_ready` is due one cycle after `start`, and `bank_we` is combinational on the beat being offered, so both are sampled in the same half cycle in which they apply. The bench counts two falling edges from the beat that completes the load. At the first it expects silence, and at the second it expects output k=0. It then compares one output per falling edge against a model built from the column order table for 32R cycles, and expects `out_valid` low at the edge after that.

// File: rtl/sbi_pkg.sv
package sbi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } sbi_state_e;

  localparam logic [1:0] SEL_PAR2 = 2'd2;

  // column visiting order: five-bit reversal of the column counter
  function automatic logic [4:0] col_perm(input logic [4:0] c);
    return {c[0], c[1], c[2], c[3], c[4]};
  endfunction

  function automatic int rows_of(input int d);
    return (d + 31) / 32;
  endfunction

  function automatic int nulls_of(input int d);
    return 32 * rows_of(d) - d;
  endfunction

  function automatic int beats_of(input int d);
    return (d + 7) / 8;
  endfunction

endpackage

// File: rtl/sbi_wr_lanes.sv
module sbi_wr_lanes #(
  parameter int LANES = 8,
  parameter int BANKS = 8,
  parameter int LEN_W = 9,
  parameter int PW    = 8
) (
  input  logic                      fire,
  input  logic [LEN_W-1:0]          beat,
  input  logic [LEN_W-1:0]          dlen,
  input  logic [4:0]                nd,
  output logic [LANES-1:0]          lane_en,
  output logic [LANES-1:0][PW-1:0]  lane_pos,
  output logic [BANKS-1:0]          bank_we
);
  localparam int AW  = LEN_W + 4;
  localparam int CPB = 32 / BANKS;
  localparam int BW  = $clog2(BANKS);

  logic [LANES-1:0][AW-1:0] idx;
  logic [LANES-1:0][AW-1:0] pos;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign idx[j]      = AW'(beat) * AW'(LANES) + AW'(j);
    assign pos[j]      = idx[j] + AW'(nd);
    assign lane_en[j]  = fire && (idx[j] < AW'(dlen));
    assign lane_pos[j] = pos[j][PW-1:0];
  end

  always_comb begin
    bank_we = '0;
    for (int j = 0; j < LANES; j++) begin
      if (lane_en[j]) bank_we[BW'(int'(pos[j][4:0]) / CPB)] = 1'b1;
    end
  end
endmodule

// File: rtl/sbi_rd_addr.sv
module sbi_rd_addr #(
  parameter int RW  = 3,
  parameter int RW1 = 4,
  parameter int PW  = 8
) (
  input  logic [4:0]     col_idx,
  input  logic [RW-1:0]  row_idx,
  input  logic [RW1-1:0] rows,
  input  logic [4:0]     nd,
  input  logic [1:0]     sel,
  output logic [PW-1:0]  rd_pos,
  output logic           rd_null
);
  logic [PW:0] base;
  logic [PW:0] total;
  logic [PW:0] bumped;

  assign base   = (PW+1)'({row_idx, sbi_pkg::col_perm(col_idx)});
  assign total  = (PW+1)'(rows) << 5;
  assign bumped = (base + 1'b1 == total) ? '0 : base + 1'b1;

  always_comb begin
    rd_pos  = (sel == sbi_pkg::SEL_PAR2) ? bumped[PW-1:0] : base[PW-1:0];
    rd_null = (PW+1)'(rd_pos) < (PW+1)'(nd);
  end
endmodule

// File: rtl/sbi_writer.sv
module sbi_writer #(
  parameter int MAX_ROWS = 8,
  parameter int LANES    = 8,
  parameter int BANKS    = 8,
  parameter int LEN_W    = $clog2(MAX_ROWS * 32 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [1:0]       stream_sel,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic [7:0]       bank_we,
  output logic             out_valid,
  output logic             out_bit,
  output logic             out_null,
  output logic             out_last
);
  import sbi_pkg::*;

  localparam int DEPTH = MAX_ROWS * 32;
  localparam int PW    = $clog2(DEPTH);
  localparam int RW    = $clog2(MAX_ROWS);
  localparam int RW1   = $clog2(MAX_ROWS + 1);

  sbi_state_e       state;
  logic [LEN_W-1:0] dlen;
  logic [LEN_W-1:0] beat;
  logic [LEN_W-1:0] nbeats;
  logic [1:0]       sel;
  logic [RW1-1:0]   rows;
  logic [4:0]       nd;
  logic [4:0]       col_idx;
  logic [RW-1:0]    row_idx;
  logic [DEPTH-1:0] mat;

  // named events for the checker
  logic                     wr_fire;
  logic                     wr_last;
  logic                     rd_step;
  logic                     rd_last;
  logic [LANES-1:0]         lane_en;
  logic [LANES-1:0][PW-1:0] lane_pos;
  logic [PW-1:0]            rd_pos;
  logic                     rd_null;

  assign in_ready = (state == ST_WRITE);
  assign wr_fire  = in_ready && in_valid;
  assign wr_last  = wr_fire && (beat == nbeats - 1'b1);
  assign rd_step  = (state == ST_READ);
  assign rd_last  = rd_step && (RW1'(row_idx) == rows - 1'b1) && (col_idx == 5'd31);

  sbi_wr_lanes #(.LANES(LANES), .BANKS(BANKS), .LEN_W(LEN_W), .PW(PW)) u_lanes (
    .fire     (wr_fire),
    .beat     (beat),
    .dlen     (dlen),
    .nd       (nd),
    .lane_en  (lane_en),
    .lane_pos (lane_pos),
    .bank_we  (bank_we)
  );

  sbi_rd_addr #(.RW(RW), .RW1(RW1), .PW(PW)) u_rd (
    .col_idx (col_idx),
    .row_idx (row_idx),
    .rows    (rows),
    .nd      (nd),
    .sel     (sel),
    .rd_pos  (rd_pos),
    .rd_null (rd_null)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      dlen    <= '0;
      nbeats  <= '0;
      beat    <= '0;
      sel     <= '0;
      rows    <= '0;
      nd      <= '0;
      col_idx <= '0;
      row_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          dlen   <= blk_len;
          sel    <= stream_sel;
          nbeats <= LEN_W'(beats_of(int'(blk_len)));
          rows   <= RW1'(rows_of(int'(blk_len)));
          nd     <= 5'(nulls_of(int'(blk_len)));
          beat   <= '0;
          state  <= ST_WRITE;
        end
        ST_WRITE: if (wr_fire) begin
          if (wr_last) begin
            state   <= ST_READ;
            col_idx <= '0;
            row_idx <= '0;
          end else begin
            beat <= beat + 1'b1;
          end
        end
        ST_READ: begin
          if (RW1'(row_idx) == rows - 1'b1) begin
            row_idx <= '0;
            col_idx <= col_idx + 1'b1;
            if (col_idx == 5'd31) state <= ST_IDLE;
          end else begin
            row_idx <= row_idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < LANES; j++) begin
      if (lane_en[j]) mat[lane_pos[j]] <= in_data[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_null  <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= rd_step;
      out_bit   <= mat[rd_pos];
      out_null  <= rd_null;
      out_last  <= rd_last;
    end
  end
endmodule

// File: rtl/sbi_writer_chk.sv
module sbi_writer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_fire,
  input logic       in_ready,
  input logic [7:0] bank_we,
  input logic       out_valid,
  input logic       out_last
);
  // R9: an accepted beat touches one to three banks
  p_beat_banks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (bank_we != 8'd0 && $countones(bank_we) <= 3));

  // R3: no write enable without an accepted beat
  p_idle_banks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |-> bank_we == 8'd0);

  // R3: loading phase persists while beats are stalled
  p_ready_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !wr_fire) |=> in_ready);

  // R8: draining and loading never overlap
  p_phase_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R8: valid drops right after the last bit
  p_last_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);

  // R8: valid only falls after a marked last bit
  p_fall_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_last));
endmodule

bind sbi_writer sbi_writer_chk u_sbi_writer_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_fire   (wr_fire),
  .in_ready  (in_ready),
  .bank_we   (bank_we),
  .out_valid (out_valid),
  .out_last  (out_last)
);

// File: tb/test_sbi_writer.sv
module test_sbi_writer;
  localparam int LEN_W = 9;
  localparam int NV    = 6;
  localparam int PERM [32] = '{0,16,8,24,4,20,12,28,2,18,10,26,6,22,14,30,
                               1,17,9,25,5,21,13,29,3,19,11,27,7,23,15,31};
  // vector table: length, stream code, seed, stall gap, busy start
  localparam int V_LEN  [NV] = '{44, 64, 33, 256, 100, 7};
  localparam int V_SEL  [NV] = '{0, 1, 2, 0, 2, 3};
  localparam int V_SEED [NV] = '{1, 5, 9, 13, 21, 30};
  localparam int V_GAP  [NV] = '{0, 1, 0, 1, 1, 0};
  localparam int V_BUSY [NV] = '{0, 0, 1, 0, 1, 0};

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [LEN_W-1:0] blk_len = '0;
  logic [1:0] stream_sel = '0;
  logic in_valid = 0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_bit, out_null, out_last;
  logic [7:0] bank_we;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sbi_writer i_sbi_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_len(blk_len),
    .stream_sel(stream_sel), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .bank_we(bank_we), .out_valid(out_valid),
    .out_bit(out_bit), .out_null(out_null), .out_last(out_last)
  );

  function automatic logic src_bit(input int i, input int seed);
    int v;
    v = i * 37 + seed * 11 + (i >> 3);
    return ^v[7:0];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_block(input int d, input int s, input int seed,
                           input int gap, input int busy);
    int r, nd, n, nb, nulls, col, row, pos, expw, p;
    r = (d + 31) / 32; nd = 32 * r - d; n = 32 * r; nb = (d + 7) / 8;
    @(negedge clk);
    start = 1; blk_len = LEN_W'(d); stream_sel = 2'(s);
    @(negedge clk);
    start = 0;
    chk("R2 in_ready after start", int'(in_ready), 1);
    for (int b = 0; b < nb; b++) begin
      if (gap != 0 && b == 1) begin
        in_valid = 0;
        #1 chk("R3 stall has no bank enable", int'(bank_we), 0);
        @(negedge clk);
        chk("R3 ready held across stall", int'(in_ready), 1);
      end
      in_valid = 1;
      for (int j = 0; j < 8; j++) in_data[j] = src_bit(8 * b + j, seed);
      if (busy != 0 && b == 0) begin
        start = 1; blk_len = LEN_W'(20); stream_sel = 2'd1;
      end
      expw = 0;
      for (int j = 0; j < 8; j++) begin
        if (8 * b + j < d) begin
          p = nd + 8 * b + j;
          expw |= 1 << ((p % 32) / 4);
        end
      end
      #1 chk("R9 bank enables", int'(bank_we), expw);
      @(negedge clk);
      start = 0;
    end
    in_valid = 0;
    chk("R3 ready low after last beat", int'(in_ready), 0);
    chk("R8 no output one cycle after last beat", int'(out_valid), 0);
    @(negedge clk);
    nulls = 0;
    for (int k = 0; k < n; k++) begin
      col = k / r; row = k % r;
      pos = row * 32 + PERM[col];
      if (s == 2) pos = (pos + 1) % n;
      chk("R8 output valid", int'(out_valid), 1);
      chk(s == 2 ? "R7 null flag" : "R6 null flag", int'(out_null), int'(pos < nd));
      if (pos >= nd)
        chk(s == 2 ? "R7 bit value" : "R6 bit value", int'(out_bit),
            int'(src_bit(pos - nd, seed)));
      if (busy != 0 && pos >= nd) chk("R10 busy start ignored", int'(out_bit),
                                      int'(src_bit(pos - nd, seed)));
      // R5: tail bits sit in columns 28..31 of the last row
      if (s != 2 && row == r - 1 && PERM[col] >= 28)
        chk("R5 tail column bit", int'(out_bit), int'(src_bit(d - 32 + PERM[col], seed)));
      chk("R8 last marker", int'(out_last), int'(k == n - 1));
      if (out_null) nulls++;
      @(negedge clk);
    end
    chk("R4 null count", nulls, nd);
    chk("R8 valid low after block", int'(out_valid), 0);
    chk("R8 idle after block", int'(in_ready), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset in_ready", int'(in_ready), 0);
    chk("R1 reset out_valid", int'(out_valid), 0);
    chk("R1 reset bank_we", int'(bank_we), 0);
    rst_n = 1;
    @(negedge clk);
    for (int v = 0; v < NV; v++)
      run_block(V_LEN[v], V_SEL[v], V_SEED[v], V_GAP[v], V_BUSY[v]);
    // reset in the middle of a load
    @(negedge clk);
    start = 1; blk_len = LEN_W'(100); stream_sel = 2'd0;
    @(negedge clk);
    start = 0; in_valid = 1; in_data = 8'hA5;
    @(negedge clk);
    rst_n = 0;
    #1;
    chk("R1 mid reset in_ready", int'(in_ready), 0);
    chk("R1 mid reset bank_we", int'(bank_we), 0);
    chk("R1 mid reset out_last", int'(out_last), 0);
    in_valid = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", int'(out_valid), 0);
    run_block(32, 1, 3, 0, 0);
    run_block(1, 2, 4, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule